// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the addressing fields of a decoded memory operation into a 32-bit offset, then into a linear address. The offset sums an optional base register value, an optional index register value shifted left by a 2-bit scale code, and a displacement that is absent, a sign-extended byte or a full 32-bit word. The base of one of six segment descriptor registers is then added to the offset. All sums wrap modulo 2^32.

Each descriptor register holds a 16-bit selector, a base, a limit and a 3-bit rights field. A write port loads one register per cycle. Every request is checked against the chosen descriptor in three ways. The access must fit under the limit. The effective privilege must not exceed what the descriptor allows. The descriptor must be present. The result appears one clock after the request, together with a valid strobe. A faulting request still returns its addresses, but they are marked unusable.

Top module: `seg_addr_gen`

## Requirements
- R1: `eff_off` equals base term + (index term << `scale_code`) + displacement term, modulo 2^32.
- R2: When `base_valid` is 0 the base term is zero. When `index_valid` is 0 the index term is zero.
- R3: `disp_size` selects the displacement term: 0 gives zero, 1 gives `disp_val[7:0]` sign-extended to 32 bits, 2 gives `disp_val`, and 3 gives zero.
- R4: `lin_addr` equals the selected descriptor's base plus `eff_off`, modulo 2^32.
- R5: `limit_fault` is 1 when `eff_off` + 2^`acc_size` - 1 is greater than the descriptor limit. The sum is taken at 33 bits, so it does not wrap.
- R6: `priv_fault` is 1 when max(`cpl`, descriptor selector bits [1:0]) is numerically greater than the descriptor privilege in rights bits [1:0].
- R7: `seg_absent` is 1 when rights bit 2 (present) is 0, or when `seg_sel` is 6 or 7. An unused select reads as an all-zero descriptor. `addr_ok` is 1 only when none of the three faults is set. Both addresses are still reported when a fault is set.
- R8: For the selected register, `tbl_index` reports selector bits [15:3], `tbl_local` reports selector bit 2 (0 = global table, 1 = local table) and `req_rpl` reports selector bits [1:0].
- R9: When `wr_en` is 1, register `wr_sel` takes the written selector, base, limit and rights at the clock edge. A write with `wr_sel` of 6 or 7 changes nothing. A request in the same cycle as a write to its own register uses the register's previous contents.
- R10: `out_valid` equals `req_valid` of the previous cycle. Result outputs change only on a cycle that follows a request.
- R11: Synchronous reset clears `out_valid` and the result outputs. It also sets every descriptor to selector 0, base 0, limit 0 and rights 0 (not present).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request this cycle |
| base_valid | input | 1 | Base term present |
| base_val | input | 32 | Base register value |
| index_valid | input | 1 | Index term present |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Index shift amount (x1, x2, x4, x8) |
| disp_size | input | 2 | Displacement size code |
| disp_val | input | 32 | Displacement bits |
| seg_sel | input | 3 | Descriptor register used by the request |
| cpl | input | 2 | Current privilege level |
| acc_size | input | 2 | Access size, 2^code bytes |
| wr_en | input | 1 | Descriptor write strobe |
| wr_sel | input | 3 | Descriptor register written |
| wr_selector | input | 16 | Selector to load |
| wr_base | input | 32 | Segment base to load |
| wr_limit | input | 32 | Segment limit to load |
| wr_rights | input | 3 | Rights to load: bit 2 present, bits 1:0 privilege |
| out_valid | output | 1 | Result valid |
| eff_off | output | 32 | Effective offset |
| lin_addr | output | 32 | Linear address |
| addr_ok | output | 1 | No fault on this result |
| limit_fault | output | 1 | Access exceeds segment limit |
| priv_fault | output | 1 | Privilege check failed |
| seg_absent | output | 1 | Descriptor not present or select unused |
| tbl_index | output | 13 | Selector table index |
| tbl_local | output | 1 | Selector table indicator |
| req_rpl | output | 2 | Selector requested privilege |

## Verification
A descriptor load and an address request that uses the same register can occur in the same clock. The bench drives this case directly: it rewrites a register's base while asking for an address through that register, and expects the old base. The next request must then see the new base. The random phase mixes writes into about a third of the cycles. The reference model computes each expected result before it applies that cycle's write, so every overlap is judged against read-before-write.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
    localparam int ADDR_W      = 32;
    localparam int SELECTOR_W  = 16;
    localparam int RIGHTS_W    = 3;
    localparam int PRESENT_BIT = 2;
    localparam int TBL_IDX_W   = SELECTOR_W - 3;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        DISP_NONE = 2'd0,
        DISP_BYTE = 2'd1,
        DISP_WORD = 2'd2,
        DISP_RSVD = 2'd3
    } disp_size_e;

    typedef struct packed {
        logic [SELECTOR_W-1:0] selector;
        addr_t                 base;
        addr_t                 limit;
        logic [RIGHTS_W-1:0]   rights;
    } seg_desc_t;

    typedef struct packed {
        addr_t                eff_off;
        addr_t                lin_addr;
        logic                 limit_fault;
        logic                 priv_fault;
        logic                 seg_absent;
        logic                 addr_ok;
        logic [TBL_IDX_W-1:0] tbl_index;
        logic                 tbl_local;
        logic [1:0]           rpl;
    } agu_result_t;

    function automatic addr_t extend_disp(disp_size_e sz, addr_t raw);
        case (sz)
            DISP_BYTE: return {{(ADDR_W-8){raw[7]}}, raw[7:0]};
            DISP_WORD: return raw;
            default:   return '0;
        endcase
    endfunction

    function automatic logic exceeds_limit(addr_t off, logic [1:0] acc_code, addr_t lim);
        logic [ADDR_W:0] span;
        logic [ADDR_W:0] last;
        span = (ADDR_W+1)'((4'd1 << acc_code) - 4'd1);
        last = {1'b0, off} + span;
        return last > {1'b0, lim};
    endfunction

    function automatic logic priv_exceeds(logic [1:0] cur, logic [1:0] req, logic [1:0] dpl);
        logic [1:0] eff;
        eff = (cur > req) ? cur : req;
        return eff > dpl;
    endfunction
endpackage

// File: rtl/sag_offset.sv
module sag_offset
    import seg_addr_pkg::*;
(
    input  logic       base_valid,
    input  addr_t      base_val,
    input  logic       index_valid,
    input  addr_t      index_val,
    input  logic [1:0] scale_code,
    input  disp_size_e disp_size,
    input  addr_t      disp_val,
    output addr_t      eff_off
);
    addr_t base_term;
    addr_t index_term;
    addr_t disp_term;

    always_comb begin
        base_term  = base_valid  ? base_val : '0;
        index_term = index_valid ? (index_val << scale_code) : '0;
        disp_term  = extend_disp(disp_size, disp_val);
        eff_off    = base_term + index_term + disp_term;
    end

    // R2, R3: with every term omitted the offset must be zero
    always_comb begin
        if (!base_valid && !index_valid && (disp_size == DISP_NONE || disp_size == DISP_RSVD))
            a_r2_empty_offset: assert (eff_off == '0);
    end
endmodule

// File: rtl/sag_desc_file.sv
module sag_desc_file
    import seg_addr_pkg::*;
#(
    parameter int NUM_SEGS  = 6,
    parameter int SEG_SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEG_SEL_W-1:0] wr_sel,
    input  seg_desc_t            wr_desc,
    input  logic [SEG_SEL_W-1:0] rd_sel,
    output seg_desc_t            rd_desc,
    output logic                 rd_hit
);
    seg_desc_t            entries [NUM_SEGS];
    logic [NUM_SEGS-1:0]  present_vec;

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entries[g] <= '0;
            else if (wr_en && wr_sel == SEG_SEL_W'(g))
                entries[g] <= wr_desc;
        end
        assign present_vec[g] = entries[g].rights[PRESENT_BIT];

        a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == SEG_SEL_W'(g)) |=>
                (entries[g].base == $past(wr_desc.base) && entries[g].limit == $past(wr_desc.limit)));
    end

    always_comb begin
        rd_desc = '0;
        rd_hit  = 1'b0;
        for (int k = 0; k < NUM_SEGS; k++) begin
            if (rd_sel == SEG_SEL_W'(k)) begin
                rd_desc = entries[k];
                rd_hit  = 1'b1;
            end
        end
    end

    a_r11_reset_absent: assert property (@(posedge clk) rst |=> (present_vec == '0));
endmodule

// File: rtl/sag_check.sv
module sag_check
    import seg_addr_pkg::*;
(
    input  seg_desc_t   desc,
    input  logic        hit,
    input  addr_t       eff_off,
    input  logic [1:0]  cpl,
    input  logic [1:0]  acc_code,
    output agu_result_t res
);
    always_comb begin
        res             = '0;
        res.eff_off     = eff_off;
        res.lin_addr    = desc.base + eff_off;
        res.seg_absent  = !hit || !desc.rights[PRESENT_BIT];
        res.limit_fault = exceeds_limit(eff_off, acc_code, desc.limit);
        res.priv_fault  = priv_exceeds(cpl, desc.selector[1:0], desc.rights[1:0]);
        res.addr_ok     = !(res.seg_absent || res.limit_fault || res.priv_fault);
        res.tbl_index   = desc.selector[SELECTOR_W-1:3];
        res.tbl_local   = desc.selector[2];
        res.rpl         = desc.selector[1:0];
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int NUM_SEGS  = 6,
    parameter int SEG_SEL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  base_valid,
    input  logic [31:0]           base_val,
    input  logic                  index_valid,
    input  logic [31:0]           index_val,
    input  logic [1:0]            scale_code,
    input  logic [1:0]            disp_size,
    input  logic [31:0]           disp_val,
    input  logic [SEG_SEL_W-1:0]  seg_sel,
    input  logic [1:0]            cpl,
    input  logic [1:0]            acc_size,
    input  logic                  wr_en,
    input  logic [SEG_SEL_W-1:0]  wr_sel,
    input  logic [15:0]           wr_selector,
    input  logic [31:0]           wr_base,
    input  logic [31:0]           wr_limit,
    input  logic [2:0]            wr_rights,
    output logic                  out_valid,
    output logic [31:0]           eff_off,
    output logic [31:0]           lin_addr,
    output logic                  addr_ok,
    output logic                  limit_fault,
    output logic                  priv_fault,
    output logic                  seg_absent,
    output logic [12:0]           tbl_index,
    output logic                  tbl_local,
    output logic [1:0]            req_rpl
);
    addr_t       off_d;
    seg_desc_t   wr_desc;
    seg_desc_t   rd_desc;
    logic        rd_hit;
    agu_result_t res_d;
    agu_result_t res_q;
    logic        valid_q;

    assign wr_desc = '{selector: wr_selector, base: wr_base, limit: wr_limit, rights: wr_rights};

    sag_offset u_offset (
        .base_valid  (base_valid),
        .base_val    (base_val),
        .index_valid (index_valid),
        .index_val   (index_val),
        .scale_code  (scale_code),
        .disp_size   (disp_size_e'(disp_size)),
        .disp_val    (disp_val),
        .eff_off     (off_d)
    );

    sag_desc_file #(.NUM_SEGS(NUM_SEGS), .SEG_SEL_W(SEG_SEL_W)) u_desc (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_desc (wr_desc),
        .rd_sel  (seg_sel),
        .rd_desc (rd_desc),
        .rd_hit  (rd_hit)
    );

    sag_check u_check (
        .desc     (rd_desc),
        .hit      (rd_hit),
        .eff_off  (off_d),
        .cpl      (cpl),
        .acc_code (acc_size),
        .res      (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid)
                res_q <= res_d;
        end
    end

    assign out_valid   = valid_q;
    assign eff_off     = res_q.eff_off;
    assign lin_addr    = res_q.lin_addr;
    assign addr_ok     = res_q.addr_ok;
    assign limit_fault = res_q.limit_fault;
    assign priv_fault  = res_q.priv_fault;
    assign seg_absent  = res_q.seg_absent;
    assign tbl_index   = res_q.tbl_index;
    assign tbl_local   = res_q.tbl_local;
    assign req_rpl     = res_q.rpl;

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);
    a_r10_hold_result: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(lin_addr) && $stable(eff_off)));
    a_r7_absent_blocks_ok: assert property (@(posedge clk) disable iff (rst)
        (req_valid && seg_sel >= SEG_SEL_W'(NUM_SEGS)) |=> (seg_absent && !addr_ok));
endmodule

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst;
    logic        req_valid, base_valid, index_valid, wr_en;
    logic [31:0] base_val, index_val, disp_val, wr_base, wr_limit;
    logic [1:0]  scale_code, disp_size, cpl, acc_size;
    logic [2:0]  seg_sel, wr_sel, wr_rights;
    logic [15:0] wr_selector;
    logic        out_valid, addr_ok, limit_fault, priv_fault, seg_absent, tbl_local;
    logic [31:0] eff_off, lin_addr;
    logic [12:0] tbl_index;
    logic [1:0]  req_rpl;

    seg_addr_gen uut (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "";

    logic [15:0] m_sel  [6];
    logic [31:0] m_base [6];
    logic [31:0] m_lim  [6];
    logic [2:0]  m_rt   [6];

    logic [31:0] e_off, e_lin, last_lin;
    logic        e_lim, e_priv, e_abs, e_ok, e_req;
    logic [15:0] e_sel;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", phase, tag, act, exp);
        end
    endtask

    function automatic void predict();
        logic [31:0] b, i, d, sb, sl;
        logic [2:0]  rt;
        logic [32:0] last;
        logic [1:0]  effp;
        b = base_valid ? base_val : 32'd0;
        i = index_valid ? (index_val << scale_code) : 32'd0;
        d = (disp_size == 2'd1) ? {{24{disp_val[7]}}, disp_val[7:0]} :
            (disp_size == 2'd2) ? disp_val : 32'd0;
        e_off = b + i + d;
        if (seg_sel < 3'd6) begin
            sb = m_base[seg_sel]; sl = m_lim[seg_sel]; rt = m_rt[seg_sel]; e_sel = m_sel[seg_sel];
        end else begin
            sb = 0; sl = 0; rt = 0; e_sel = 0;
        end
        e_lin  = sb + e_off;
        last   = {1'b0, e_off} + 33'((1 << acc_size) - 1);
        e_lim  = last > {1'b0, sl};
        effp   = (cpl > e_sel[1:0]) ? cpl : e_sel[1:0];
        e_priv = effp > rt[1:0];
        e_abs  = !(seg_sel < 3'd6) || !rt[2];
        e_ok   = !(e_lim || e_priv || e_abs);
        e_req  = req_valid;
    endfunction

    task automatic step();
        predict();
        if (wr_en && wr_sel < 3'd6) begin
            m_sel[wr_sel] = wr_selector; m_base[wr_sel] = wr_base;
            m_lim[wr_sel] = wr_limit;    m_rt[wr_sel]   = wr_rights;
        end
        @(posedge clk);
        @(negedge clk);
        chk("R10 out_valid", 32'(out_valid), 32'(e_req));
        if (e_req) begin
            chk("R1/R2/R3 eff_off", eff_off, e_off);
            chk("R4 lin_addr", lin_addr, e_lin);
            chk("R5 limit_fault", 32'(limit_fault), 32'(e_lim));
            chk("R6 priv_fault", 32'(priv_fault), 32'(e_priv));
            chk("R7 seg_absent", 32'(seg_absent), 32'(e_abs));
            chk("R7 addr_ok", 32'(addr_ok), 32'(e_ok));
            chk("R8 tbl_index", 32'(tbl_index), 32'(e_sel[15:3]));
            chk("R8 tbl_local", 32'(tbl_local), 32'(e_sel[2]));
            chk("R8 req_rpl", 32'(req_rpl), 32'(e_sel[1:0]));
            last_lin = e_lin;
        end else begin
            chk("R10 hold lin_addr", lin_addr, last_lin);
        end
        req_valid = 0; wr_en = 0;
    endtask

    task automatic load(input logic [2:0] s, input logic [15:0] sel, input logic [31:0] b,
                        input logic [31:0] l, input logic [2:0] r);
        wr_en = 1; wr_sel = s; wr_selector = sel; wr_base = b; wr_limit = l; wr_rights = r;
    endtask

    task automatic ask(input logic bv, input logic [31:0] b, input logic iv, input logic [31:0] ix,
                       input logic [1:0] sc, input logic [1:0] ds, input logic [31:0] dv,
                       input logic [2:0] s, input logic [1:0] c, input logic [1:0] a);
        req_valid = 1; base_valid = bv; base_val = b; index_valid = iv; index_val = ix;
        scale_code = sc; disp_size = ds; disp_val = dv; seg_sel = s; cpl = c; acc_size = a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EA1_0042));
        for (int k = 0; k < 6; k++) begin
            m_sel[k] = 0; m_base[k] = 0; m_lim[k] = 0; m_rt[k] = 0;
        end
        last_lin = 0;
        rst = 1; req_valid = 0; wr_en = 0;
        base_valid = 0; base_val = 0; index_valid = 0; index_val = 0;
        scale_code = 0; disp_size = 0; disp_val = 0; seg_sel = 0; cpl = 0; acc_size = 0;
        wr_sel = 0; wr_selector = 0; wr_base = 0; wr_limit = 0; wr_rights = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        phase = "R11 reset";
        chk("out_valid", 32'(out_valid), 0);
        chk("lin_addr", lin_addr, 0);
        chk("seg_absent", 32'(seg_absent), 0);
        rst = 0;

        phase = "R11 post-reset descriptor";
        ask(1, 32'h10, 0, 0, 0, 0, 0, 3'd0, 2'd0, 2'd0); step();

        phase = "R9 load";
        load(3'd1, 16'h001B, 32'h0000_1000, 32'h0000_00FF, 3'b111); step();
        phase = "R5 limit boundary";
        ask(1, 32'hF0, 0, 0, 0, 0, 0, 3'd1, 2'd3, 2'd2); step();
        ask(1, 32'hFC, 0, 0, 0, 0, 0, 3'd1, 2'd3, 2'd2); step();
        ask(1, 32'hFD, 0, 0, 0, 0, 0, 3'd1, 2'd3, 2'd2); step();
        phase = "R3 negative byte displacement";
        ask(1, 32'h20, 0, 0, 0, 2'd1, 32'hFFFF_FF80, 3'd1, 2'd3, 2'd0); step();
        phase = "R3 reserved size code";
        ask(1, 32'h20, 0, 0, 0, 2'd3, 32'h44, 3'd1, 2'd3, 2'd0); step();
        phase = "R2 index only scaled";
        ask(0, 32'hDEAD, 1, 32'd3, 2'd3, 0, 0, 3'd1, 2'd3, 2'd0); step();
        phase = "R1 wrap";
        load(3'd3, 16'h0007, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 3'b100); step();
        ask(1, 32'hFFFF_FFFF, 1, 32'h8000_0000, 2'd1, 2'd2, 32'd2, 3'd3, 2'd0, 2'd0); step();
        ask(1, 32'h20, 0, 0, 0, 0, 0, 3'd3, 2'd0, 2'd0); step();
        phase = "R6 privilege";
        load(3'd2, 16'h0010, 32'h0, 32'hFFFF, 3'b100); step();
        ask(1, 32'h0, 0, 0, 0, 0, 0, 3'd2, 2'd1, 2'd0); step();
        ask(1, 32'h0, 0, 0, 0, 0, 0, 3'd2, 2'd0, 2'd0); step();
        load(3'd2, 16'h0012, 32'h0, 32'hFFFF, 3'b101); step();
        ask(1, 32'h0, 0, 0, 0, 0, 0, 3'd2, 2'd0, 2'd0); step();
        phase = "R9 same-cycle write and read";
        load(3'd1, 16'h001B, 32'h0005_0000, 32'h0000_00FF, 3'b111);
        ask(1, 32'h4, 0, 0, 0, 0, 0, 3'd1, 2'd3, 2'd0); step();
        ask(1, 32'h4, 0, 0, 0, 0, 0, 3'd1, 2'd3, 2'd0); step();
        phase = "R9 write to unused select";
        load(3'd7, 16'hFFFF, 32'h1234, 32'hFFFF_FFFF, 3'b111); step();
        phase = "R7 unused select";
        ask(1, 32'h4, 0, 0, 0, 0, 0, 3'd7, 2'd0, 2'd0); step();
        ask(1, 32'h4, 0, 0, 0, 0, 0, 3'd6, 2'd0, 2'd0); step();

        phase = "R1/R4/R5/R6/R8 random";
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] mask;
            if ($urandom_range(0, 2) == 0)
                load(3'($urandom_range(0, 7)), 16'($urandom), 32'($urandom),
                     ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 4096)) : 32'($urandom),
                     3'($urandom));
            mask = ($urandom_range(0, 1) != 0) ? 32'h0000_03FF : 32'hFFFF_FFFF;
            if ($urandom_range(0, 3) != 0)
                ask(1'($urandom), 32'($urandom) & mask, 1'($urandom), 32'($urandom) & mask,
                    2'($urandom), 2'($urandom), 32'($urandom), 3'($urandom_range(0, 7)),
                    2'($urandom), 2'($urandom));
            step();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule